// File: doc/BRIEF.md
# Serial Command Word Receiver with Pass-Through Output

This block is the front end of a multi-channel converter's control path. It takes command words from a three-wire serial port: a serial clock, a serial data input and an active-low select line that also marks the end of a frame. Bits shift into a 32-stage register on rising serial-clock edges, but only while select is low. The oldest bit in that register is driven on a serial data output, which lets several devices hang on one port in series, each passing traffic on to the next.

When select rises, the block freezes the newest 24 bits as one command word. The word is made of a 4-bit command, a 4-bit address and 16 bits of data. That edge is brought into the system clock domain and the word is presented to a downstream decoder on a valid/ready output. Back-pressure rules: the word and `out_valid` stay unchanged until a cycle with `out_valid` and `out_ready` both high. If another frame ends while a word is still waiting, the newer word replaces the older one and `out_valid` stays high, so only the latest command is ever offered. When `out_ready` is held high, every frame produces a valid pulse exactly one cycle long.

A frame is either 24 or 32 bits long. Only the last 24 bits are taken, so the first 8 bits of a long frame are don't-care. Chained devices need 32-bit frames.

Top module: `ser_cmd_frontend`

## Requirements
- R1: While `rst_n` is low, and right after it is released, `ser_dout` is 0, `out_valid` is 0 and all 32 shift stages hold 0.
- R2: Rising `ser_clk` edges while `ser_sel_n` is high change no shift stage and produce no word. A later frame's `ser_dout` sequence and its word show no trace of those edges.
- R3: After each falling `ser_clk` edge, `ser_dout` equals the bit that entered on the rising edge 32 selected rising edges earlier. It is 0 while fewer than 32 bits have entered since reset.
- R4: For a 24-bit frame, the word holds the bits in arrival order with the first bit at word bit 23. `out_cmd` = word[23:20], `out_addr` = word[19:16], `out_data` = word[15:0], each most significant bit first.
- R5: For a 32-bit frame, the first 8 bits do not affect the word. The word equals the last 24 bits, as in R4.
- R6: `out_valid` rises within 4 `clk` cycles after the rising edge of `ser_sel_n`.
- R7: While `out_valid` is high and `out_ready` is low, `out_valid` stays high and the word stays unchanged. After a cycle with both high, `out_valid` is low unless another frame has ended.
- R8: A frame that ends while a word is still pending replaces that word, and `out_valid` stays high.
- R9: With `out_ready` held high, each frame gives exactly one cycle of `out_valid`.
- R10: Two blocks sharing `ser_clk` and `ser_sel_n`, with the first one's `ser_dout` feeding the second one's `ser_din`, take a 64-bit transfer as follows: the second block receives the first 32 bits and the first block receives the last 32 bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock for the output side |
| rst_n | input | 1 | Asynchronous active-low reset, both domains |
| ser_clk | input | 1 | Serial clock |
| ser_din | input | 1 | Serial data in, sampled on rising `ser_clk` |
| ser_sel_n | input | 1 | Active-low select; its rising edge ends the frame |
| ser_dout | output | 1 | Pass-through data, changes on falling `ser_clk` |
| out_valid | output | 1 | Command word available |
| out_ready | input | 1 | Downstream accepts the word |
| out_cmd | output | 4 | Command field of the word |
| out_addr | output | 4 | Address field of the word |
| out_data | output | 16 | Data field of the word |

## Verification
The bench toggles the serial clock while select is high and then checks the pass-through stream. A block that shifts on every edge would put the wrong bits on `ser_dout`. Frames of both lengths check field alignment: a design that takes the first 24 bits instead of the last 24 returns the padding bits as the command. Holding ready low across two frames shows whether the word is dropped, kept stale, or released early. A two-block chain sent 64 bits shows whether the delay is off by one stage or whether the output changes on the wrong clock edge.

// File: rtl/sercmd_pkg.sv
package sercmd_pkg;
  localparam int CMD_W  = 4;
  localparam int ADDR_W = 4;
  localparam int DATA_W = 16;
  localparam int WORD_W = CMD_W + ADDR_W + DATA_W;

  typedef struct packed {
    logic [CMD_W-1:0]  cmd;
    logic [ADDR_W-1:0] addr;
    logic [DATA_W-1:0] data;
  } word_t;
endpackage

// File: rtl/sercmd_shift.sv
module sercmd_shift #(
  parameter int CHAIN_W = 32
) (
  input  logic               ser_clk,
  input  logic               rst_n,
  input  logic               sel_n,
  input  logic               din,
  output logic               dout,
  output logic [CHAIN_W-1:0] chain_q
);
  // rising edge: shift in only while selected
  always_ff @(posedge ser_clk or negedge rst_n) begin
    if (!rst_n)      chain_q <= '0;
    else if (!sel_n) chain_q <= {chain_q[CHAIN_W-2:0], din};
  end

  // falling edge: re-emit the oldest stage
  always_ff @(negedge ser_clk or negedge rst_n) begin
    if (!rst_n) dout <= 1'b0;
    else        dout <= chain_q[CHAIN_W-1];
  end
endmodule

// File: rtl/sercmd_capture.sv
module sercmd_capture
  import sercmd_pkg::*;
(
  input  logic  sel_n,
  input  logic  rst_n,
  input  word_t low_bits,
  output word_t word_q
);
  // frame end edge freezes the newest bits
  always_ff @(posedge sel_n or negedge rst_n) begin
    if (!rst_n) word_q <= '0;
    else        word_q <= low_bits;
  end
endmodule

// File: rtl/sercmd_sync.sv
module sercmd_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic async_in,
  output logic rise
);
  logic [STAGES-1:0] stg;
  logic              last_q;

  // idle level of select is high: reset to 1 so release gives no edge
  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[0] <= 1'b1;
          else        stg[0] <= async_in;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[i] <= 1'b1;
          else        stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b1;
    else        last_q <= stg[STAGES-1];
  end

  assign rise = stg[STAGES-1] & ~last_q;
endmodule

// File: rtl/sercmd_outreg.sv
module sercmd_outreg
  import sercmd_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  load,
  input  word_t word_in,
  input  logic  ready,
  output logic  valid,
  output word_t word_out
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      valid    <= 1'b0;
      word_out <= '0;
    end else if (load) begin
      valid    <= 1'b1;
      word_out <= word_in;
    end else if (valid && ready) begin
      valid    <= 1'b0;
    end
  end
endmodule

// File: rtl/ser_cmd_frontend.sv
module ser_cmd_frontend
  import sercmd_pkg::*;
#(
  parameter int CHAIN_W     = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              ser_clk,
  input  logic              ser_din,
  input  logic              ser_sel_n,
  output logic              ser_dout,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [CMD_W-1:0]  out_cmd,
  output logic [ADDR_W-1:0] out_addr,
  output logic [DATA_W-1:0] out_data
);
  logic [CHAIN_W-1:0] chain_q;
  word_t              cap_word;
  word_t              out_word;
  logic               sel_rise;

  sercmd_shift #(.CHAIN_W(CHAIN_W)) u_shift (
    .ser_clk (ser_clk),
    .rst_n   (rst_n),
    .sel_n   (ser_sel_n),
    .din     (ser_din),
    .dout    (ser_dout),
    .chain_q (chain_q)
  );

  sercmd_capture u_cap (
    .sel_n    (ser_sel_n),
    .rst_n    (rst_n),
    .low_bits (word_t'(chain_q[WORD_W-1:0])),
    .word_q   (cap_word)
  );

  sercmd_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .async_in (ser_sel_n),
    .rise     (sel_rise)
  );

  sercmd_outreg u_out (
    .clk      (clk),
    .rst_n    (rst_n),
    .load     (sel_rise),
    .word_in  (cap_word),
    .ready    (out_ready),
    .valid    (out_valid),
    .word_out (out_word)
  );

  assign out_cmd  = out_word.cmd;
  assign out_addr = out_word.addr;
  assign out_data = out_word.data;
endmodule

// File: rtl/sercmd_chk.sv
module sercmd_chk
  import sercmd_pkg::*;
#(
  parameter int CHAIN_W = 32
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ser_clk,
  input logic               ser_sel_n,
  input logic [CHAIN_W-1:0] chain_q,
  input logic               sel_rise,
  input word_t              cap_word,
  input logic               out_valid,
  input logic               out_ready,
  input logic [DATA_W-1:0]  out_data,
  input logic [CMD_W-1:0]   out_cmd,
  input logic [ADDR_W-1:0]  out_addr
);
  // R2
  desel_hold_chk: assert property (@(posedge ser_clk) disable iff (!rst_n)
    ser_sel_n |=> $stable(chain_q));

  // R7
  stall_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready && !sel_rise) |=>
      (out_valid && $stable(out_data) && $stable(out_cmd) && $stable(out_addr)));

  // R7
  accept_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_ready && !sel_rise) |=> !out_valid);

  // R8
  frame_load_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sel_rise |=> (out_valid && {out_cmd, out_addr, out_data} == $past(cap_word)));

  // R1
  always_comb begin
    if (!rst_n) begin
      reset_idle_chk: assert (!out_valid);
    end
  end
endmodule

bind ser_cmd_frontend sercmd_chk #(.CHAIN_W(CHAIN_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ser_clk   (ser_clk),
  .ser_sel_n (ser_sel_n),
  .chain_q   (chain_q),
  .sel_rise  (sel_rise),
  .cap_word  (cap_word),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data),
  .out_cmd   (out_cmd),
  .out_addr  (out_addr)
);

// File: tb/tb_ser_cmd_frontend.sv
`timescale 1ns/1ps
module tb_ser_cmd_frontend;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        ser_clk = 1'b0;
  logic        ser_din = 1'b0;
  logic        ser_sel_n = 1'b1;
  logic        ser_dout, dout2;
  logic        out_valid, out_ready, v2;
  logic [3:0]  out_cmd, out_addr, c2, a2;
  logic [15:0] out_data, d2;

  int errors = 0;
  int checks = 0;
  bit done = 1'b0;
  logic [31:0] model = '0;

  always #5 clk = ~clk;

  ser_cmd_frontend dut (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(ser_din),
    .ser_sel_n(ser_sel_n), .ser_dout(ser_dout), .out_valid(out_valid),
    .out_ready(out_ready), .out_cmd(out_cmd), .out_addr(out_addr), .out_data(out_data));

  ser_cmd_frontend dut2 (
    .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_din(ser_dout),
    .ser_sel_n(ser_sel_n), .ser_dout(dout2), .out_valid(v2),
    .out_ready(1'b1), .out_cmd(c2), .out_addr(a2), .out_data(d2));

  function automatic logic [23:0] exp_word(input logic [31:0] bits);
    return bits[23:0];
  endfunction

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // one serial bit; all times stay at 3 mod 10, away from clk edges
  task automatic shift_bit(input logic b, input string req);
    ser_din = b;
    #10 ser_clk = 1'b1;
    if (!ser_sel_n) model = {model[30:0], b};
    #10 ser_clk = 1'b0;
    #10;
    chk(ser_dout === model[31], req, {31'd0, ser_dout}, {31'd0, model[31]});
  endtask

  task automatic send(input logic [31:0] bits, input int n);
    ser_sel_n = 1'b0;
    #10;
    for (int i = n - 1; i >= 0; i--) shift_bit(bits[i], "R3");
    #10 ser_sel_n = 1'b1;
  endtask

  function automatic logic [23:0] cur_word();
    return {out_cmd, out_addr, out_data};
  endfunction

  // wait for valid with ready high; check latency and pulse width
  task automatic expect_pulse(input logic [23:0] w, input string req);
    int lat = 0;
    int width = 0;
    logic [23:0] seen = '0;
    for (int i = 0; i < 12; i++) begin
      #10;
      if (out_valid) begin
        if (width == 0) begin lat = i + 1; seen = cur_word(); end
        width++;
      end
    end
    chk(lat >= 1 && lat <= 4, "R6", lat, 4);
    chk(width == 1, "R9", width, 1);
    chk(seen === w, req, {8'd0, seen}, {8'd0, w});
  endtask

  initial begin : watchdog
    #1500000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks + 1);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] f;
    logic [23:0] wa, wb;
    void'($urandom(32'd1234));
    out_ready = 1'b1;
    #3;
    #20;
    // R1 reset state
    chk(ser_dout === 1'b0, "R1", {31'd0, ser_dout}, 0);
    chk(out_valid === 1'b0, "R1", {31'd0, out_valid}, 0);
    rst_n = 1'b1;
    #30;
    chk(out_valid === 1'b0, "R1", {31'd0, out_valid}, 0);
    // R1/R3: first 32 bits out are zero
    send(32'hA5C3_0F96, 32);
    expect_pulse(exp_word(32'hA5C3_0F96), "R5");

    // R4 directed 24-bit frame, field split
    send(32'h00_9_3_BEEF, 24);
    expect_pulse(24'h93BEEF, "R4");
    chk(out_cmd === 4'h9 && out_addr === 4'h3 && out_data === 16'hBEEF, "R4",
        {8'd0, cur_word()}, 32'h0093BEEF);

    // R2 edges while deselected are ignored
    for (int i = 0; i < 13; i++) shift_bit(1'($urandom), "R2");
    for (int i = 0; i < 6; i++) begin
      #10;
      chk(out_valid === 1'b0, "R2", {31'd0, out_valid}, 0);
    end
    send(32'h0012_3456, 24);
    expect_pulse(24'h123456, "R2");

    // R5 32-bit frame with padding
    send(32'hFF_7_1_0001, 32);
    expect_pulse(24'h710001, "R5");

    // random frames of both lengths
    for (int k = 0; k < 20; k++) begin
      f = $urandom;
      if ($urandom % 2) begin
        send(f, 32);
        expect_pulse(exp_word(f), "R5");
      end else begin
        send(f, 24);
        expect_pulse(exp_word(f), "R4");
      end
    end

    // R7/R8 back-pressure and replacement
    out_ready = 1'b0;
    wa = 24'h4A_1234; wb = 24'hC2_5678;
    send({8'd0, wa}, 24);
    #60;
    chk(out_valid === 1'b1 && cur_word() === wa, "R7", {8'd0, cur_word()}, {8'd0, wa});
    #100;
    chk(out_valid === 1'b1 && cur_word() === wa, "R7", {8'd0, cur_word()}, {8'd0, wa});
    send({8'd0, wb}, 24);
    #60;
    chk(out_valid === 1'b1 && cur_word() === wb, "R8", {8'd0, cur_word()}, {8'd0, wb});
    out_ready = 1'b1;
    #10;
    chk(out_valid === 1'b0, "R7", {31'd0, out_valid}, 0);
    #30;

    // R10 two-block chain, 64-bit transfer
    begin
      logic [31:0] first_w, last_w;
      logic [23:0] s2;
      int hit2;
      first_w = 32'h55_6_2_ABCD;
      last_w  = 32'h33_8_5_1357;
      hit2 = 0; s2 = '0;
      ser_sel_n = 1'b0;
      #10;
      for (int i = 31; i >= 0; i--) shift_bit(first_w[i], "R3");
      for (int i = 31; i >= 0; i--) shift_bit(last_w[i], "R3");
      #10 ser_sel_n = 1'b1;
      for (int i = 0; i < 8; i++) begin
        #10;
        if (v2) begin hit2++; s2 = {c2, a2, d2}; end
        if (out_valid) chk(cur_word() === last_w[23:0], "R10", {8'd0, cur_word()}, {8'd0, last_w[23:0]});
      end
      chk(hit2 == 1 && s2 === first_w[23:0], "R10", {8'd0, s2}, {8'd0, first_w[23:0]});
    end

    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule